// File: doc/BRIEF.md
# Accumulator ALU with condition flags

This block is the accumulator datapath of a small 16-bit DSP core. It holds a 32-bit accumulator and four condition flags (carry/borrow, zero, overflow, negative), the flags living in the top four bits of a 16-bit status word. Each cycle with `op_valid` high it applies one operation. The operand is either a full 16-bit word or a short immediate taken from its low byte.

Add, subtract and compare work on the accumulator's upper half only. Load and the bitwise operations act on the whole 32-bit value, with the operand placed in the upper half. A modify operation can shift the accumulator right or left by one, negate it, or take its absolute value. A modify runs only when the condition evaluator agrees. The condition evaluator is combinational on the current flags, and its `cond_true` output also serves the core's conditional branches and calls.

Top module: `acc_alu`

## Requirements
- R1: After reset `acc` is 0 and `status` is 0. Status bits 11..0 always read 0. The flags sit at bit 15 = N, bit 14 = V, bit 13 = Z and bit 12 = L.
- R2: `op_code` 2 (subtract) and 4 (add) write `acc[31:16] op operand` modulo 2^16 into `acc[31:16]` and leave `acc[15:0]` unchanged.
- R3: `op_code` 3 (compare) updates the flags exactly as subtract would and leaves `acc` unchanged.
- R4: Add, subtract and compare take their flags from the 16-bit result. Z is set when the result is 0 and N copies result bit 15. L is the carry out (add) or the borrow, meaning upper half < operand as unsigned (subtract and compare). V is two's-complement overflow.
- R5: `op_code` 1 (load) puts the operand in `acc[31:16]` and keeps `acc[15:0]`. Z is set when the whole 32-bit accumulator is 0, N copies bit 31, and L and V are kept.
- R6: `op_code` 5, 6 and 7 (AND, OR, XOR) combine `{operand, 16'h0}` with the full accumulator, so AND clears the low word. Z and N come from the 32-bit result, and L and V are kept.
- R7: With `short_imm` high, the operand used is `{8'h00, operand[7:0]}`.
- R8: `cond_true` is combinational. `cond_sel` 0 gives 1, 5 gives Z == `cond_pol`, 7 gives N == `cond_pol`, and every other value gives 0.
- R9: `op_code` 8 (modify), when `cond_true` is 1, applies the `mod_sel` operation to all 32 bits. The codes are 2 = logical shift right by one, 3 = shift left by one, 6 = negate and 7 = absolute value. It then sets Z/N from the 32-bit result and keeps L and V.
- R10: A modify with `cond_true` 0, or with a `mod_sel` outside {2,3,6,7}, changes neither `acc` nor `status`.
- R11: With `op_valid` low, or with `op_code` 0 or 9..15, `acc` and `status` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Apply `op_code` this cycle |
| op_code | input | 4 | Operation select |
| operand | input | 16 | Operand word |
| short_imm | input | 1 | Use zero-extended low byte of `operand` |
| cond_sel | input | 4 | Condition code |
| cond_pol | input | 1 | Polarity that the tested flag must match |
| mod_sel | input | 3 | Modify sub-code |
| acc | output | 32 | Accumulator |
| status | output | 16 | Status word with flags in bits 15..12 |
| cond_true | output | 1 | Condition evaluation result |

## Verification
The assertions assume that `op_code`, `mod_sel` and `cond_sel` are known, two-state values on every cycle outside reset. They also assume that `cond_true` is sampled in the same cycle as the modify it gates. The bench drives every control field from `$urandom` over its full range, so unsupported opcodes, sub-codes and condition codes all occur, and it changes inputs only on the falling edge. Directed cases cover add carry to zero, subtract overflow at 0x8000, AND clearing a nonzero low word, absolute value of a negative value, and short immediates with a nonzero high byte.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int HALF_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [3:0]          op_code,
  input  logic [HALF_W-1:0]   operand,
  input  logic                short_imm,
  input  logic [3:0]          cond_sel,
  input  logic                cond_pol,
  input  logic [2:0]          mod_sel,
  output logic [2*HALF_W-1:0] acc,
  output logic [HALF_W-1:0]   status,
  output logic                cond_true
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int LOW_W  = HALF_W - 4;

  localparam logic [3:0] OP_LOAD = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_CMP  = 4'd3;
  localparam logic [3:0] OP_ADD  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_MOD  = 4'd8;

  logic [FULL_W-1:0] acc_q, acc_d, mod_res;
  logic              l_q, z_q, v_q, n_q;
  logic              l_d, z_d, v_d, n_d;
  logic              zn_full, mod_hit;

  logic [HALF_W-1:0] opnd, hi;
  logic [HALF_W:0]   sum, dif;
  logic [FULL_W-1:0] wide;
  logic              add_ovf, sub_ovf;

  assign opnd = short_imm ? {{(HALF_W-SHORT_W){1'b0}}, operand[SHORT_W-1:0]} : operand;
  assign hi   = acc_q[FULL_W-1:HALF_W];
  assign wide = {opnd, {HALF_W{1'b0}}};
  assign sum  = {1'b0, hi} + {1'b0, opnd};
  assign dif  = {1'b0, hi} - {1'b0, opnd};
  assign add_ovf = (hi[HALF_W-1] == opnd[HALF_W-1]) && (sum[HALF_W-1] != hi[HALF_W-1]);
  assign sub_ovf = (hi[HALF_W-1] != opnd[HALF_W-1]) && (dif[HALF_W-1] != hi[HALF_W-1]);

  always_comb begin
    case (cond_sel)
      4'd0:    cond_true = 1'b1;
      4'd5:    cond_true = (z_q == cond_pol);
      4'd7:    cond_true = (n_q == cond_pol);
      default: cond_true = 1'b0;
    endcase
  end

  always_comb begin
    mod_hit = 1'b1;
    case (mod_sel)
      3'd2:    mod_res = acc_q >> 1;
      3'd3:    mod_res = acc_q << 1;
      3'd6:    mod_res = -acc_q;
      3'd7:    mod_res = acc_q[FULL_W-1] ? -acc_q : acc_q;
      default: begin mod_res = acc_q; mod_hit = 1'b0; end
    endcase
  end

  always_comb begin
    acc_d = acc_q;
    l_d = l_q; z_d = z_q; v_d = v_q; n_d = n_q;
    zn_full = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_LOAD: begin acc_d[FULL_W-1:HALF_W] = opnd; zn_full = 1'b1; end
        OP_SUB, OP_CMP: begin
          if (op_code == OP_SUB) acc_d[FULL_W-1:HALF_W] = dif[HALF_W-1:0];
          l_d = dif[HALF_W];
          v_d = sub_ovf;
          z_d = (dif[HALF_W-1:0] == '0);
          n_d = dif[HALF_W-1];
        end
        OP_ADD: begin
          acc_d[FULL_W-1:HALF_W] = sum[HALF_W-1:0];
          l_d = sum[HALF_W];
          v_d = add_ovf;
          z_d = (sum[HALF_W-1:0] == '0);
          n_d = sum[HALF_W-1];
        end
        OP_AND: begin acc_d = acc_q & wide; zn_full = 1'b1; end
        OP_OR:  begin acc_d = acc_q | wide; zn_full = 1'b1; end
        OP_XOR: begin acc_d = acc_q ^ wide; zn_full = 1'b1; end
        OP_MOD: begin
          if (cond_true && mod_hit) begin
            acc_d = mod_res;
            zn_full = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (zn_full) begin
      z_d = (acc_d == '0);
      n_d = acc_d[FULL_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      l_q <= 1'b0; z_q <= 1'b0; v_q <= 1'b0; n_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      l_q <= l_d; z_q <= z_d; v_q <= v_d; n_q <= n_d;
    end
  end

  assign acc    = acc_q;
  assign status = {n_q, v_q, z_q, l_q, {LOW_W{1'b0}}};

  assert_cmp_keeps_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_CMP |=> $stable(acc));

  assert_arith_low_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_ADD || op_code == OP_SUB)
    |=> acc[HALF_W-1:0] == $past(acc[HALF_W-1:0]));

  assert_logic_zn_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)
    |=> (status[HALF_W-3] == (acc == '0)) && (status[HALF_W-1] == acc[FULL_W-1]));

  assert_and_clears_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_AND |=> acc[HALF_W-1:0] == '0);

  assert_load_keeps_lv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_LOAD |=> $stable(status[HALF_W-2]) && $stable(status[HALF_W-4]));

  assert_mod_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_MOD &&
    (!cond_true || !(mod_sel == 3'd2 || mod_sel == 3'd3 || mod_sel == 3'd6 || mod_sel == 3'd7))
    |=> $stable(acc) && $stable(status));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc) && $stable(status));

  assert_cond_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cond_sel == 4'd0 |-> cond_true);
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, short_imm = 1'b0, cond_pol = 1'b0;
  logic [3:0] op_code = '0, cond_sel = '0;
  logic [15:0] operand = '0;
  logic [2:0] mod_sel = '0;
  logic [31:0] acc;
  logic [15:0] status;
  logic cond_true;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_acc;
  logic m_l, m_z, m_v, m_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .short_imm(short_imm), .cond_sel(cond_sel),
    .cond_pol(cond_pol), .mod_sel(mod_sel), .acc(acc), .status(status),
    .cond_true(cond_true));

  function automatic bit cond_m(input logic [3:0] cs, input logic cp);
    case (cs)
      4'd0: return 1'b1;
      4'd5: return m_z == cp;
      4'd7: return m_n == cp;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] status_m();
    return {m_n, m_v, m_z, m_l, 12'h000};
  endfunction

  function automatic string tag_of(input logic v, input logic [3:0] oc);
    if (!v) return "R11";
    case (oc)
      4'd1: return "R5";
      4'd2, 4'd4: return "R2/R4";
      4'd3: return "R3";
      4'd5, 4'd6, 4'd7: return "R6";
      4'd8: return "R9/R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step();
    logic [15:0] x, hi;
    logic [16:0] r;
    bit ct;
    x  = short_imm ? {8'h00, operand[7:0]} : operand;
    hi = m_acc[31:16];
    ct = cond_m(cond_sel, cond_pol);
    if (!op_valid) return;
    case (op_code)
      4'd1: begin m_acc[31:16] = x; m_z = (m_acc == 0); m_n = m_acc[31]; end
      4'd2, 4'd3: begin
        r = {1'b0, hi} - {1'b0, x};
        m_l = r[16]; m_v = (hi[15] != x[15]) && (r[15] != hi[15]);
        m_z = (r[15:0] == 0); m_n = r[15];
        if (op_code == 4'd2) m_acc[31:16] = r[15:0];
      end
      4'd4: begin
        r = {1'b0, hi} + {1'b0, x};
        m_l = r[16]; m_v = (hi[15] == x[15]) && (r[15] != hi[15]);
        m_z = (r[15:0] == 0); m_n = r[15];
        m_acc[31:16] = r[15:0];
      end
      4'd5: begin m_acc = m_acc & {x, 16'h0}; m_z = (m_acc == 0); m_n = m_acc[31]; end
      4'd6: begin m_acc = m_acc | {x, 16'h0}; m_z = (m_acc == 0); m_n = m_acc[31]; end
      4'd7: begin m_acc = m_acc ^ {x, 16'h0}; m_z = (m_acc == 0); m_n = m_acc[31]; end
      4'd8: if (ct && (mod_sel == 2 || mod_sel == 3 || mod_sel == 6 || mod_sel == 7)) begin
        case (mod_sel)
          3'd2: m_acc = m_acc >> 1;
          3'd3: m_acc = m_acc << 1;
          3'd6: m_acc = -m_acc;
          default: if (m_acc[31]) m_acc = -m_acc;
        endcase
        m_z = (m_acc == 0); m_n = m_acc[31];
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, check cond_true, clock, check state.
  task automatic step(input logic v, input logic [3:0] oc, input logic [15:0] od,
                      input logic sh, input logic [3:0] cs, input logic cp, input logic [2:0] ms);
    string t;
    op_valid = v; op_code = oc; operand = od; short_imm = sh;
    cond_sel = cs; cond_pol = cp; mod_sel = ms;
    #1;
    chk("R8", "cond_true", {31'b0, cond_true}, {31'b0, cond_m(cs, cp)});
    t = tag_of(v, oc);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(t, "acc", acc, m_acc);
    chk(t, "status", {16'h0, status}, {16'h0, status_m()});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5A_77C3));
    m_acc = '0; {m_l, m_z, m_v, m_n} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "reset acc", acc, 32'h0);
    chk("R1", "reset status", {16'h0, status}, 32'h0);

    step(1, 4'd1, 16'h0000, 0, 4'd0, 0, 3'd0);
    chk("R5", "load zero Z", {16'h0, status}, 32'h2000);
    step(1, 4'd0, 16'h0, 0, 4'd5, 1, 3'd0);
    step(1, 4'd0, 16'h0, 0, 4'd3, 1, 3'd0);
    chk("R8", "code 3 false", {31'b0, cond_true}, 32'h0);

    step(1, 4'd1, 16'hFFFF, 0, 4'd0, 0, 3'd0);
    step(1, 4'd4, 16'h0001, 0, 4'd0, 0, 3'd0);
    chk("R4", "add carry to zero", {16'h0, status}, 32'h3000);
    chk("R2", "add wraps", acc, 32'h0);

    step(1, 4'd1, 16'h8000, 0, 4'd0, 0, 3'd0);
    step(1, 4'd2, 16'h0001, 0, 4'd0, 0, 3'd0);
    chk("R4", "sub overflow", {16'h0, status}, 32'h4000);
    chk("R2", "sub result", acc, 32'h7FFF0000);

    step(1, 4'd1, 16'h0001, 0, 4'd0, 0, 3'd0);
    step(1, 4'd8, 16'h0, 0, 4'd0, 0, 3'd2);
    chk("R9", "shr into low word", acc, 32'h00008000);
    step(1, 4'd5, 16'hFFFF, 0, 4'd0, 0, 3'd0);
    chk("R6", "and clears low", acc, 32'h0);

    step(1, 4'd1, 16'hFFFF, 0, 4'd0, 0, 3'd0);
    step(1, 4'd8, 16'h0, 0, 4'd7, 1, 3'd7);
    chk("R9", "abs of negative", acc, 32'h00010000);
    step(1, 4'd8, 16'h0, 0, 4'd0, 0, 3'd4);
    chk("R10", "unsupported subcode", acc, 32'h00010000);
    step(1, 4'd8, 16'h0, 0, 4'd9, 0, 3'd6);
    chk("R10", "cond false blocks", acc, 32'h00010000);

    step(1, 4'd1, 16'hAB12, 1, 4'd0, 0, 3'd0);
    chk("R7", "short immediate", acc, 32'h00120000);
    step(1, 4'd3, 16'hFF12, 1, 4'd0, 0, 3'd0);
    chk("R3", "cmp equal short", {16'h0, status}, 32'h2000);
    step(0, 4'd4, 16'h1234, 0, 4'd0, 0, 3'd0);
    chk("R11", "idle hold", acc, 32'h00120000);

    for (int i = 0; i < 4000; i++) begin
      logic v;
      v = ($urandom % 10) != 0;
      step(v, 4'($urandom), 16'($urandom), 1'($urandom % 4 == 0),
           ($urandom % 2) ? 4'($urandom % 8) : 4'($urandom),
           1'($urandom), 3'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule